// File: doc/BRIEF.md
# Single-channel DMA transfer engine

This block moves a run of words from a device read port into memory without the processor copying any data. Software loads a word-granular memory address and a word count through a small register window, then writes a control word with the start bit set. The engine then runs a fixed loop for each word. It requests the shared bus and waits for the grant. It asks the device for a word and writes that word to memory in its own bus cycle. It then waits for the device to acknowledge that the word has landed. After each word the address steps up by one and the count steps down by one.

Bus ownership follows a mode bit that is captured at start. In cycle-stealing mode the engine drops its bus request after every word and requests the bus again for the next word. In burst mode it keeps the request raised from the first grant until the last word is acknowledged. A single interrupt line rises only when the whole count has been moved. It stays high until software writes the clear bit. A plain grant input stands in for the bus arbiter.

Top module: `dma_engine`

## Requirements
- R1: After reset the engine is idle. `bus_req`, `dev_rd_req`, `mem_we`, `dev_fin` and `irq` are low, and the address, count and status registers all read zero.
- R2: While idle, a write to select 0 loads the memory address and a write to select 1 loads the word count. Both read back on `cpu_rdata` at the same selects. A write to select 2 is the control word: bit 0 is start, bit 1 picks burst mode (1) or cycle-stealing mode (0), and bit 2 clears done. A read of select 2 returns status: bit 0 busy, bit 1 done, bit 2 the captured mode.
- R3: Each word follows a fixed order. First `dev_rd_req` is held until `dev_rd_valid`, and `dev_rd_data` is captured. Then `mem_we` drives that word to `mem_addr` equal to the current address, held until `mem_ready`. Then `dev_fin` is held until `dev_ack`.
- R4: Each word ends with its accepted `dev_ack`. Then the address register increases by one and the count register decreases by one, and both can be read while the transfer runs.
- R5: `irq` and the done bit rise only after the final word is acknowledged, never while busy. They stay high until a control write with bit 2 set.
- R6: In cycle-stealing mode `bus_req` goes low for at least one cycle between consecutive words, so a run of N words raises it N times.
- R7: In burst mode `bus_req` stays high from the first request until the final acknowledge, so a run raises it exactly once.
- R8: A start with a count of zero sets done and `irq` on the next cycle. No bus request is made.
- R9: While busy, writes to the address and count registers and further start commands have no effect.
- R10: No device or memory activity takes place while the bus request is waiting for `bus_gnt`.
- R11: If a done-clear write lands in the same cycle as the final acknowledge, done still ends up set. A start of a non-zero transfer clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Selected register contents |
| irq | output | 1 | Completion interrupt, held until cleared |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter stand-in |
| dev_rd_req | output | 1 | Read request to the device |
| dev_rd_valid | input | 1 | Device word is valid |
| dev_rd_data | input | 32 | Device word |
| dev_fin | output | 1 | Word is in memory; asks the device to acknowledge |
| dev_ack | input | 1 | Device acknowledge that ends a word |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory write accepted |

## Verification
The tightest collision is a software write of the done-clear bit in the same cycle that the device acknowledges the last word, which is also the cycle that sets done. The bench provokes it by polling the count register until it reads one while `dev_fin` is high. Its model raises `dev_ack` in that same cycle, so the bench issues the clear there. It judges the outcome by requiring `irq` and the done bit to be high afterwards and the address to have stepped past the last word.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSREQ,
        ST_DEVRD,
        ST_MEMWR,
        ST_DEVACK,
        ST_GAP
    } seq_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_BITS = 3;

    typedef struct packed {
        logic clear;
        logic burst;
        logic start;
    } ctrl_s;

    typedef struct packed {
        logic burst;
        logic done;
        logic busy;
    } stat_s;

    function automatic ctrl_s decode_ctrl(input logic [CTRL_BITS-1:0] bits);
        return ctrl_s'(bits);
    endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_sel,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          busy,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          burst_q,
    output logic          done_q,
    output logic          launch,
    output logic          cnt_is_one
);
    ctrl_s ctrl_w;
    logic  ctrl_hit, start_ok, zero_start, clear_req, final_step;

    assign ctrl_w     = decode_ctrl(cpu_wdata[CTRL_BITS-1:0]);
    assign ctrl_hit   = cpu_wr && (cpu_sel == SEL_CTRL);
    assign start_ok   = ctrl_hit && ctrl_w.start && !busy;
    assign launch     = start_ok && (cnt_q != '0);
    assign zero_start = start_ok && (cnt_q == '0);
    assign clear_req  = ctrl_hit && ctrl_w.clear;
    assign cnt_is_one = (cnt_q == CW'(1));
    assign final_step = step && cnt_is_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            burst_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (step) begin
                addr_q <= addr_q + AW'(1);
                cnt_q  <= cnt_q - CW'(1);
            end else if (cpu_wr && !busy) begin
                if (cpu_sel == SEL_ADDR)  addr_q <= cpu_wdata[AW-1:0];
                if (cpu_sel == SEL_COUNT) cnt_q  <= cpu_wdata[CW-1:0];
            end
            if (start_ok) burst_q <= ctrl_w.burst;
            if (final_step || zero_start) done_q <= 1'b1;
            else if (clear_req || launch) done_q <= 1'b0;
        end
    end

    stat_s stat_w;
    assign stat_w = '{burst: burst_q, done: done_q, busy: busy};

    always_comb begin
        cpu_rdata = '0;
        case (cpu_sel)
            SEL_ADDR:  cpu_rdata[AW-1:0] = addr_q;
            SEL_COUNT: cpu_rdata[CW-1:0] = cnt_q;
            SEL_CTRL:  cpu_rdata[CTRL_BITS-1:0] = stat_w;
            default:   cpu_rdata = '0;
        endcase
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt_q == $past(cnt_q) - CW'(1)) && (addr_q == $past(addr_q) + AW'(1)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !step |=> (addr_q == $past(addr_q)) && (cnt_q == $past(cnt_q)));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_q && !ctrl_hit |=> done_q);

    // R8
    zero_done_chk: assert property (@(posedge clk) disable iff (rst)
        zero_start |=> done_q && !busy);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          burst,
    input  logic          cnt_is_one,
    output logic          busy,
    output logic          step,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          dev_rd_req,
    input  logic          dev_rd_valid,
    input  logic [DW-1:0] dev_rd_data,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    output logic          dev_fin,
    input  logic          dev_ack
);
    seq_state_e state_q, state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (launch) state_d = ST_BUSREQ;
            ST_BUSREQ: if (bus_gnt) state_d = ST_DEVRD;
            ST_DEVRD:  if (dev_rd_valid) state_d = ST_MEMWR;
            ST_MEMWR:  if (mem_ready) state_d = ST_DEVACK;
            ST_DEVACK: if (dev_ack) begin
                if (cnt_is_one) state_d = ST_IDLE;
                else if (burst) state_d = ST_DEVRD;
                else            state_d = ST_GAP;
            end
            ST_GAP:    state_d = ST_BUSREQ;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DEVRD && dev_rd_valid) data_q <= dev_rd_data;
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign bus_req    = (state_q == ST_BUSREQ) || (state_q == ST_DEVRD) ||
                        (state_q == ST_MEMWR)  || (state_q == ST_DEVACK);
    assign dev_rd_req = (state_q == ST_DEVRD);
    assign mem_we     = (state_q == ST_MEMWR);
    assign dev_fin    = (state_q == ST_DEVACK);
    assign mem_wdata  = data_q;
    assign step       = dev_fin && dev_ack;

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        dev_rd_req && dev_rd_valid |=> mem_we && !dev_rd_req);

    // R3
    wr_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we && mem_ready |=> dev_fin && !mem_we);

    // R6
    steal_gap_chk: assert property (@(posedge clk) disable iff (rst)
        step && !burst && !cnt_is_one |=> !bus_req);

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        step && burst && !cnt_is_one |=> bus_req && dev_rd_req);

    // R10
    gnt_wait_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt && !dev_rd_req && !mem_we && !dev_fin |=> !mem_we && !dev_fin);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_sel,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          dev_rd_req,
    input  logic          dev_rd_valid,
    input  logic [DW-1:0] dev_rd_data,
    output logic          dev_fin,
    input  logic          dev_ack,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready
);
    logic          busy, step, burst_q, done_q, launch, cnt_is_one;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;

    dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cpu_wr     (cpu_wr),
        .cpu_sel    (cpu_sel),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .busy       (busy),
        .step       (step),
        .addr_q     (addr_q),
        .cnt_q      (cnt_q),
        .burst_q    (burst_q),
        .done_q     (done_q),
        .launch     (launch),
        .cnt_is_one (cnt_is_one)
    );

    dma_seq #(.DW(DW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .burst        (burst_q),
        .cnt_is_one   (cnt_is_one),
        .busy         (busy),
        .step         (step),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .dev_rd_req   (dev_rd_req),
        .dev_rd_valid (dev_rd_valid),
        .dev_rd_data  (dev_rd_data),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .dev_fin      (dev_fin),
        .dev_ack      (dev_ack)
    );

    assign irq      = done_q;
    assign mem_addr = addr_q;

    // R5
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);
endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr = 1'b0;
    logic [1:0]    cpu_sel = 2'd0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          irq, bus_req, dev_rd_req, dev_fin, mem_we;
    logic          bus_gnt = 1'b0, dev_rd_valid = 1'b0, dev_ack = 1'b0, mem_ready = 1'b0;
    logic [DW-1:0] dev_rd_data, mem_wdata;
    logic [AW-1:0] mem_addr;

    logic gnt_en = 1'b1;
    int   tests = 0;
    int   fails = 0;

    int serial = 0;
    int wr_n = 0;
    int rises = 0;
    int falls = 0;
    int irq_busy_seen = 0;
    logic prev_req = 1'b0;
    logic [AW-1:0] wr_addr [0:63];
    logic [DW-1:0] wr_data [0:63];

    always #4 clk = ~clk;

    dma_engine #(.DW(DW), .AW(AW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .dev_rd_req(dev_rd_req),
        .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
        .dev_fin(dev_fin), .dev_ack(dev_ack), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
    );

    assign dev_rd_data = 32'hA500_0000 | DW'(serial);

    // device, memory and arbiter stand-ins respond one cycle after a request
    always @(negedge clk) begin
        bus_gnt      <= bus_req && gnt_en;
        dev_rd_valid <= dev_rd_req;
        mem_ready    <= mem_we;
        dev_ack      <= dev_fin;
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (dev_rd_req && dev_rd_valid) serial <= serial + 1;
            if (mem_we && mem_ready) begin
                wr_addr[wr_n[5:0]] <= mem_addr;
                wr_data[wr_n[5:0]] <= mem_wdata;
                wr_n <= wr_n + 1;
            end
            if (bus_req && !prev_req) rises <= rises + 1;
            if (!bus_req && prev_req) falls <= falls + 1;
            if (irq && (bus_req || dev_rd_req || mem_we || dev_fin)) irq_busy_seen <= irq_busy_seen + 1;
            prev_req <= bus_req;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [DW-1:0] data);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = data;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [DW-1:0] val);
        @(negedge clk);
        cpu_sel = sel;
        #1 val = cpu_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic run_and_check(input string tag, input logic [AW-1:0] base,
                                 input int n, input bit burst, input int exp_rises);
        int s0, w0, r0, b0;
        logic [DW-1:0] v;
        s0 = serial; w0 = wr_n; r0 = rises; b0 = irq_busy_seen;
        cpu_write(dma_pkg::SEL_ADDR, DW'(base));
        cpu_write(dma_pkg::SEL_COUNT, DW'(n));
        cpu_write(dma_pkg::SEL_CTRL, burst ? 32'h3 : 32'h1);
        wait_irq();
        @(negedge clk);
        check(wr_n - w0 == n, {tag, " R3 word count"}, wr_n - w0, n);
        for (int i = 0; i < n; i++) begin
            check(wr_addr[(w0 + i) % 64] == base + AW'(i), {tag, " R3 addr"},
                  wr_addr[(w0 + i) % 64], base + AW'(i));
            check(wr_data[(w0 + i) % 64] == (32'hA500_0000 | DW'(s0 + i)), {tag, " R3 data"},
                  wr_data[(w0 + i) % 64], 32'hA500_0000 | DW'(s0 + i));
        end
        check(rises - r0 == exp_rises, {tag, burst ? " R7 bus grabs" : " R6 bus grabs"},
              rises - r0, exp_rises);
        check(irq_busy_seen == b0, {tag, " R5 irq while busy"}, irq_busy_seen - b0, 0);
        cpu_read(dma_pkg::SEL_ADDR, v);
        check(v == DW'(base + AW'(n)), {tag, " R4 final addr"}, v, base + AW'(n));
        cpu_read(dma_pkg::SEL_COUNT, v);
        check(v == 0, {tag, " R4 final count"}, v, 0);
        cpu_read(dma_pkg::SEL_CTRL, v);
        check(v[1:0] == 2'b10 && irq, {tag, " R5 done set"}, {v[1:0], irq}, 3'b101);
        check(v[2] == burst, {tag, " R2 mode bit"}, v[2], burst);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check(!bus_req && !irq && !dev_rd_req && !mem_we && !dev_fin, "R1 outputs idle",
              {bus_req, irq, dev_rd_req, mem_we, dev_fin}, 0);
        cpu_read(dma_pkg::SEL_ADDR, v);  check(v == 0, "R1 addr zero", v, 0);
        cpu_read(dma_pkg::SEL_COUNT, v); check(v == 0, "R1 count zero", v, 0);
        cpu_read(dma_pkg::SEL_CTRL, v);  check(v == 0, "R1 status zero", v, 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] v;
        cpu_write(dma_pkg::SEL_ADDR, 32'h0123);
        cpu_write(dma_pkg::SEL_COUNT, 32'd7);
        cpu_read(dma_pkg::SEL_ADDR, v);  check(v == 32'h0123, "R2 addr readback", v, 32'h0123);
        cpu_read(dma_pkg::SEL_COUNT, v); check(v == 7, "R2 count readback", v, 7);
    endtask

    task automatic t_hold_clear();
        for (int i = 0; i < 6; i++) @(negedge clk);
        check(irq, "R5 irq held", irq, 1);
        cpu_write(dma_pkg::SEL_CTRL, 32'h4);
        check(!irq, "R5 irq cleared", irq, 0);
    endtask

    task automatic t_zero();
        int r0;
        logic [DW-1:0] v;
        r0 = rises;
        cpu_write(dma_pkg::SEL_COUNT, 32'd0);
        cpu_write(dma_pkg::SEL_CTRL, 32'h1);
        check(irq, "R8 zero start irq", irq, 1);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(rises == r0 && !bus_req, "R8 no bus request", rises - r0, 0);
        cpu_read(dma_pkg::SEL_CTRL, v);
        check(v[1:0] == 2'b10, "R8 status done", v[1:0], 2'b10);
        cpu_write(dma_pkg::SEL_CTRL, 32'h4);
    endtask

    task automatic t_busy_ignore();
        int w0, r0;
        logic [DW-1:0] v;
        w0 = wr_n; r0 = rises;
        cpu_write(dma_pkg::SEL_ADDR, 32'h0300);
        cpu_write(dma_pkg::SEL_COUNT, 32'd3);
        cpu_write(dma_pkg::SEL_CTRL, 32'h1);
        cpu_write(dma_pkg::SEL_ADDR, 32'h0777);
        cpu_write(dma_pkg::SEL_COUNT, 32'd9);
        cpu_write(dma_pkg::SEL_CTRL, 32'h3);
        wait_irq();
        @(negedge clk);
        check(wr_n - w0 == 3, "R9 word count unchanged", wr_n - w0, 3);
        check(wr_addr[(w0 + 2) % 64] == 16'h0302, "R9 addr unchanged", wr_addr[(w0 + 2) % 64], 16'h0302);
        check(rises - r0 == 3, "R9 mode unchanged", rises - r0, 3);
        cpu_read(dma_pkg::SEL_ADDR, v);
        check(v == 32'h0303, "R9 final addr", v, 32'h0303);
        cpu_write(dma_pkg::SEL_CTRL, 32'h4);
    endtask

    task automatic t_grant_wait();
        int w0;
        logic [DW-1:0] v;
        w0 = wr_n;
        gnt_en = 1'b0;
        cpu_write(dma_pkg::SEL_ADDR, 32'h0400);
        cpu_write(dma_pkg::SEL_COUNT, 32'd2);
        cpu_write(dma_pkg::SEL_CTRL, 32'h1);
        for (int i = 0; i < 12; i++) @(negedge clk);
        check(bus_req && !dev_rd_req && !mem_we, "R10 waiting on grant",
              {bus_req, dev_rd_req, mem_we}, 3'b100);
        check(wr_n == w0, "R10 no write before grant", wr_n - w0, 0);
        cpu_read(dma_pkg::SEL_COUNT, v);
        check(v == 2, "R10 count untouched", v, 2);
        gnt_en = 1'b1;
        wait_irq();
        @(negedge clk);
        check(wr_n - w0 == 2, "R10 words after grant", wr_n - w0, 2);
        cpu_write(dma_pkg::SEL_CTRL, 32'h4);
    endtask

    task automatic t_clear_race();
        logic [DW-1:0] v;
        bit hit = 0;
        cpu_write(dma_pkg::SEL_ADDR, 32'h0500);
        cpu_write(dma_pkg::SEL_COUNT, 32'd2);
        cpu_write(dma_pkg::SEL_CTRL, 32'h1);
        cpu_sel = dma_pkg::SEL_COUNT;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            #1;
            if (dev_fin && cpu_rdata == 1) begin
                hit = 1;
                cpu_wr = 1'b1; cpu_sel = dma_pkg::SEL_CTRL; cpu_wdata = 32'h4;
                @(negedge clk);
                cpu_wr = 1'b0;
                break;
            end
        end
        check(hit, "R11 race reached", hit, 1);
        #1;
        check(irq, "R11 done survives clear", irq, 1);
        cpu_read(dma_pkg::SEL_ADDR, v);
        check(v == 32'h0502, "R11 final addr", v, 32'h0502);
        cpu_write(dma_pkg::SEL_COUNT, 32'd1);
        cpu_write(dma_pkg::SEL_CTRL, 32'h1);
        check(!irq, "R11 start clears done", irq, 1'b0);
        wait_irq();
        cpu_write(dma_pkg::SEL_CTRL, 32'h4);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        run_and_check("steal", 16'h0100, 4, 1'b0, 4);
        t_hold_clear();
        run_and_check("burst", 16'h0200, 5, 1'b1, 1);
        cpu_write(dma_pkg::SEL_CTRL, 32'h4);
        t_zero();
        t_busy_ignore();
        t_grant_wait();
        t_clear_race();
        summary();
    end
endmodule